// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block moves blocks of words between peripheral devices and memory without the processor touching each word. It has two channels. Each channel keeps its own memory pointer, its own remaining-word counter and its own control and status bits. Software sets these through a small register write port and reads them back through the same address lines. A start command arms a channel. From then on, whenever that channel's device signals it is ready, the engine claims the memory bus and issues one memory access at the channel's pointer. It hands the word across, advances the pointer by one and counts down. When the counter reaches zero the channel goes idle, raises its done flag and, if enabled, drives its interrupt line.

The engine owns a single memory port and shares it with the processor. Direct transfers take precedence over the processor. Each channel picks one of two bus policies:

- **Cycle-stealing:** the bus is handed back after every word, so processor accesses slip in between words.
- **Burst:** the bus is held from the first word until the block is complete.

When both channels want the bus at the same moment, a channel marked as fast beats one that is not. When the marks are equal, channel 0 wins.

Top module: `dual_dma_engine`

## Requirements
- R1: After reset every channel register reads zero. A write stores the pointer (select 0), the counter (select 1) and, in the control register (select 2), the configuration bits: bit 3 direction (0 device-to-memory, 1 memory-to-device), bit 4 burst, bit 5 interrupt enable, bit 6 fast. The status read at select 2 returns busy in bit 0, done in bit 1, error in bit 2 and the configuration in bits 3 to 6. A control write with bit 0 set starts the channel; bit 1 set clears done and error.
- R2: For each word, the memory access carries the channel's current pointer. In device-to-memory mode it is a write of the device's data; in memory-to-device mode it is a read whose data goes to the device together with that channel's acknowledge. After each acknowledged word the pointer rises by one and the counter falls by one.
- R3: When the last word completes, busy clears and done sets. The channel's interrupt line equals done AND interrupt enable. Writing the clear bit drops done and the interrupt.
- R4: The two channels keep separate registers. A transfer on one channel leaves the other channel's pointer unchanged.
- R5: Starting with a counter of zero does not set busy and sets done at once.
- R6: While a channel is busy, writes to its pointer or counter are ignored. A start while busy does not restart the channel; it sets the error bit, which the clear bit removes.
- R7: In cycle-stealing mode, the engine releases the bus for at least one cycle after each word that is not the last, and a pending processor request is granted in that cycle.
- R8: In burst mode, from the first word until the last, the processor is never granted, even while the device stalls.
- R9: A processor request is not granted in a cycle where the engine is idle and a busy channel's device is ready.
- R10: When both channels are ready in the same cycle, the fast channel is served first. If both or neither is fast, channel 0 is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_chan | input | 1 | Channel selected for write and read |
| cfg_sel | input | 2 | Register select: 0 pointer, 1 counter, 2 control/status |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Read-back of the selected register |
| dev_req | input | 2 | Per-channel device ready for a word |
| dev_ack | output | 2 | Per-channel word-moved pulse |
| dev_rdata | input | 2*DATA_W | Per-channel data from device (channel 0 in low half) |
| dev_wdata | output | DATA_W | Data to the acknowledged device |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ack | input | 1 | Memory access completes this cycle |
| proc_req | input | 1 | Processor wants the bus |
| proc_gnt | output | 1 | Processor is granted the bus |
| irq | output | 2 | Per-channel interrupt request |

## Verification
The hardest situations to reach from the ports involve timing. One is a burst that must keep the bus through cycles where its device is not ready. The other is two channels becoming ready in exactly the same cycle. For the first, the bench gates device readiness with a phase that toggles every cycle while the processor requests the bus continuously, and it counts any grant seen between the first and last word. For the second, it arms both channels while their devices are held off, sweeps all four combinations of the fast marks, and then releases both devices on the same clock edge before recording which acknowledge appears first.

// File: rtl/dual_dma_pkg.sv
// Shared definitions for the two-channel DMA engine: register selects,
// control/status bit positions, channel configuration and sequencer states.
package dual_dma_pkg;
    localparam int CH_N = 2;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_t;

    // control write bits
    localparam int B_START = 0;
    localparam int B_CLEAR = 1;
    // shared control/status configuration bits
    localparam int B_DIR   = 3;
    localparam int B_BURST = 4;
    localparam int B_IRQEN = 5;
    localparam int B_FAST  = 6;
    // status read bits
    localparam int S_BUSY  = 0;
    localparam int S_DONE  = 1;
    localparam int S_ERR   = 2;

    typedef struct packed {
        logic dir;     // 0: device to memory, 1: memory to device
        logic burst;   // 1: hold bus for whole block
        logic irq_en;  // 1: done drives interrupt
        logic fast;    // 1: wins ties against a non-fast channel
    } chan_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_MOVE = 2'd1,
        SEQ_GAP  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dma_chan_regs.sv
// One channel's register set: memory pointer, word counter, configuration
// and busy/done/error flags.
// Assumes wr_en is already decoded for this channel, and that step is only
// raised by the sequencer while this channel is busy.
module dma_chan_regs
    import dual_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  count,
    output logic              busy,
    output logic              done,
    output logic              err,
    output chan_cfg_t         cfg,
    output logic              last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // flags the word in flight as the final one of the block
    assign last = (count == ONE);

    // register updates from word steps and software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            count <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
            cfg   <= '0;
        end else begin
            if (step) begin
                addr  <= addr + 1'b1;
                count <= count - 1'b1;
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
            if (wr_en) begin
                case (reg_sel_t'(wr_sel))
                    SEL_ADDR: begin
                        if (!busy) addr <= wr_data;
                    end
                    SEL_COUNT: begin
                        if (!busy) count <= wr_data[CNT_W-1:0];
                    end
                    SEL_CTRL: begin
                        if (wr_data[B_CLEAR]) begin
                            done <= 1'b0;
                            err  <= 1'b0;
                        end
                        if (busy) begin
                            if (wr_data[B_START]) err <= 1'b1;
                        end else begin
                            cfg.dir    <= wr_data[B_DIR];
                            cfg.burst  <= wr_data[B_BURST];
                            cfg.irq_en <= wr_data[B_IRQEN];
                            cfg.fast   <= wr_data[B_FAST];
                            if (wr_data[B_START]) begin
                                if (count == '0) begin
                                    done <= 1'b1;
                                end else begin
                                    busy <= 1'b1;
                                    done <= 1'b0;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_step_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (busy && count != '0));

    assert_busy_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (count != '0));

    assert_done_rise_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);
endmodule

// File: rtl/dma_pick.sv
// Fixed-priority channel picker: the fast channel wins, and ties go to
// channel 0. Assumes exactly two channels.
module dma_pick (
    input  logic [1:0] pend,
    input  logic [1:0] fast,
    output logic       win
);
    // channel 1 wins only if alone or uniquely fast
    always_comb begin
        win = pend[1] & (~pend[0] | (fast[1] & ~fast[0]));
    end

    // the winner must be a pending channel
    always_comb begin
        if (pend != 2'b00) begin
            assert_pick_pending_R10: assert (pend[win]);
        end
    end
endmodule

// File: rtl/dma_seq.sv
// Bus sequencer. It claims the bus for the picked channel and issues one
// memory access per device-ready word. It releases the bus after each word
// in cycle-stealing mode, or after the last word in burst mode.
// Assumes the owner channel stays busy until its last step.
module dma_seq
    import dual_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pend,
    input  logic       win,
    input  logic [1:0] dev_req,
    input  logic [1:0] burst,
    input  logic [1:0] last,
    input  logic       mem_ack,
    output logic       owner,
    output logic       mem_req,
    output logic [1:0] step,
    output logic       hold
);
    seq_state_t state;

    // request memory only while moving and the owner's device is ready
    assign mem_req = (state == SEQ_MOVE) & dev_req[owner];
    // one step pulse to the owner when memory accepts the word
    assign step    = (mem_req & mem_ack) ? (2'b01 << owner) : 2'b00;
    // bus is kept from the processor while moving or about to move
    assign hold    = (state == SEQ_MOVE) | ((state == SEQ_IDLE) & (pend != 2'b00));

    // state and owner progression
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            owner <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (pend != 2'b00) begin
                        owner <= win;
                        state <= SEQ_MOVE;
                    end
                end
                SEQ_MOVE: begin
                    if (mem_req && mem_ack && (last[owner] || !burst[owner]))
                        state <= SEQ_GAP;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assert_steal_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !burst[owner]) |=> !hold);

    assert_burst_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && burst[owner] && !last[owner]) |=> hold);
endmodule

// File: rtl/dual_dma_engine.sv
// Two-channel DMA engine top. It instantiates a register set per channel,
// the channel picker and the bus sequencer, and muxes the memory, device,
// read-back and processor-grant paths.
// Assumes ADDR_W >= 8 and CNT_W <= ADDR_W, and that the device holds
// dev_req until acknowledged or no longer ready.
module dual_dma_engine
    import dual_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_chan,
    input  logic [1:0]            cfg_sel,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    output logic [ADDR_W-1:0]     cfg_rdata,
    input  logic [1:0]            dev_req,
    output logic [1:0]            dev_ack,
    input  logic [2*DATA_W-1:0]   dev_rdata,
    output logic [DATA_W-1:0]     dev_wdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    input  logic                  mem_ack,
    input  logic                  proc_req,
    output logic                  proc_gnt,
    output logic [1:0]            irq
);
    logic [ADDR_W-1:0] ch_addr  [CH_N];
    logic [CNT_W-1:0]  ch_count [CH_N];
    chan_cfg_t         ch_cfg   [CH_N];
    logic [CH_N-1:0]   ch_busy, ch_done, ch_err, ch_last;
    logic [CH_N-1:0]   ch_fast, ch_burst, pend, step;
    logic              win, owner, hold;

    for (genvar g = 0; g < CH_N; g++) begin : g_chan
        dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_chan == g[0])),
            .wr_sel  (cfg_sel),
            .wr_data (cfg_wdata),
            .step    (step[g]),
            .addr    (ch_addr[g]),
            .count   (ch_count[g]),
            .busy    (ch_busy[g]),
            .done    (ch_done[g]),
            .err     (ch_err[g]),
            .cfg     (ch_cfg[g]),
            .last    (ch_last[g])
        );
        assign pend[g]     = ch_busy[g] & dev_req[g];
        assign ch_fast[g]  = ch_cfg[g].fast;
        assign ch_burst[g] = ch_cfg[g].burst;
        assign irq[g]      = ch_done[g] & ch_cfg[g].irq_en;
    end

    dma_pick u_pick (
        .pend (pend),
        .fast (ch_fast),
        .win  (win)
    );

    dma_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .win     (win),
        .dev_req (dev_req),
        .burst   (ch_burst),
        .last    (ch_last),
        .mem_ack (mem_ack),
        .owner   (owner),
        .mem_req (mem_req),
        .step    (step),
        .hold    (hold)
    );

    // memory and device data paths follow the owning channel
    assign mem_addr  = ch_addr[owner];
    assign mem_we    = ~ch_cfg[owner].dir;
    assign mem_wdata = dev_rdata[owner*DATA_W +: DATA_W];
    assign dev_wdata = mem_rdata;
    assign dev_ack   = step;
    // processor gets the bus whenever the engine does not claim it
    assign proc_gnt  = proc_req & ~hold;

    // register read-back mux
    always_comb begin
        cfg_rdata = '0;
        case (reg_sel_t'(cfg_sel))
            SEL_ADDR:  cfg_rdata = ch_addr[cfg_chan];
            SEL_COUNT: cfg_rdata = ADDR_W'(ch_count[cfg_chan]);
            SEL_CTRL: begin
                cfg_rdata[S_BUSY]  = ch_busy[cfg_chan];
                cfg_rdata[S_DONE]  = ch_done[cfg_chan];
                cfg_rdata[S_ERR]   = ch_err[cfg_chan];
                cfg_rdata[B_DIR]   = ch_cfg[cfg_chan].dir;
                cfg_rdata[B_BURST] = ch_cfg[cfg_chan].burst;
                cfg_rdata[B_IRQEN] = ch_cfg[cfg_chan].irq_en;
                cfg_rdata[B_FAST]  = ch_cfg[cfg_chan].fast;
            end
            default: cfg_rdata = '0;
        endcase
    end

    assert_proc_excludes_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proc_gnt |-> !mem_req);

    assert_ack_to_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack != 2'b00) |-> ((dev_ack & ch_busy) == dev_ack));
endmodule

// File: tb/dual_dma_engine_test.sv
// Sweep bench for the two-channel DMA engine: every channel, direction,
// bus mode and block length 1..4, plus zero-count, locked-register and
// channel-priority cases.
module dual_dma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic        cfg_chan;
    logic [1:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic [1:0]  dev_req, dev_ack, dev_en;
    logic [31:0] dev_rdata;
    logic [15:0] dev_wdata;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        proc_req, proc_gnt;
    logic [1:0]  irq;

    logic [15:0] mem [0:255];
    logic [15:0] dev_got [2][8];
    int          dev_idx [2];
    int          prog_addr [2];
    logic        stall, phase;
    int          checks = 0, fails = 0;
    logic        mon_on;
    int          mon_ch, mon_n, acks, gnt, first_ch;

    always #10 clk = ~clk;

    dual_dma_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dev_req(dev_req), .dev_ack(dev_ack), .dev_rdata(dev_rdata),
        .dev_wdata(dev_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .proc_req(proc_req), .proc_gnt(proc_gnt), .irq(irq)
    );

    // zero-wait memory and devices that count their own words
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[7:0]];
    assign dev_req   = dev_en & {2{~stall | phase}};
    assign dev_rdata = {16'hC100 | 16'(dev_idx[1]), 16'hC000 | 16'(dev_idx[0])};

    always @(posedge clk) begin
        phase <= ~phase;
        if (mem_req && mem_ack && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        for (int c = 0; c < 2; c++) begin
            if (dev_ack[c]) begin
                dev_got[c][dev_idx[c] % 8] <= dev_wdata;
                dev_idx[c] <= dev_idx[c] + 1;
            end
        end
    end

    // observe grants between words and which channel is served first
    always @(negedge clk) begin
        if (mon_on) begin
            if (acks >= 1 && acks < mon_n && proc_gnt) gnt <= gnt + 1;
            if (dev_ack[mon_ch]) acks <= acks + 1;
            if (first_ch < 0 && dev_ack != 2'b00) first_ch <= dev_ack[1] ? 1 : 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int sel, input int data);
        cfg_we = 1'b1; cfg_chan = ch[0]; cfg_sel = sel[1:0]; cfg_wdata = data[15:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int sel, output int v);
        cfg_chan = ch[0]; cfg_sel = sel[1:0];
        #1 v = int'(cfg_rdata);
    endtask

    task automatic wait_idle(input int ch);
        int v;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            rd(ch, 2, v);
            if ((v & 1) == 0) break;
        end
    endtask

    task automatic run_xfer(input int ch, input int dir, input int bst, input int n, input int base);
        int v, bad, ien, cfgb;
        ien  = dir ^ ch;
        cfgb = (dir << 3) | (bst << 4) | (ien << 5);
        for (int i = 0; i < n; i++)
            mem[base + i] = (dir != 0) ? 16'(16'h5000 + (ch << 8) + (n << 4) + i) : 16'h0000;
        dev_idx[ch] = 0;
        stall = (bst == 1) && (n % 2 == 0);
        mon_ch = ch; mon_n = n; acks = 0; gnt = 0; first_ch = -1;
        wr(ch, 0, base);
        wr(ch, 1, n);
        wr(ch, 2, 1 | cfgb);
        rd(ch, 0, v); chk("R1 pointer readback", v, base);
        rd(ch, 2, v); chk("R1 status after start", v, 1 | cfgb);
        mon_on = 1'b1;
        dev_en[ch] = 1'b1;
        wait_idle(ch);
        dev_en[ch] = 1'b0;
        mon_on = 1'b0;
        rd(ch, 0, v); chk("R2 final pointer", v, base + n);
        rd(ch, 1, v); chk("R2 final count", v, 0);
        rd(ch, 2, v); chk("R3 done status", v, 2 | cfgb);
        chk("R3 irq follows enable", int'(irq[ch]), ien);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (dir == 0) begin
                if (mem[base + i] != (16'hC000 | 16'(ch << 8) | 16'(i))) bad++;
            end else begin
                if (dev_got[ch][i] != mem[base + i]) bad++;
            end
        end
        chk("R2 data words", bad, 0);
        chk("R2 acknowledge count", acks, n);
        if (bst != 0) chk("R8 no grant inside burst", gnt, 0);
        else          chk("R7 grant between stolen words", int'(gnt >= n - 1), 1);
        rd(1 - ch, 0, v); chk("R4 other channel pointer", v, prog_addr[1 - ch]);
        prog_addr[ch] = base + n;
        wr(ch, 2, 2 | cfgb);
        rd(ch, 2, v); chk("R3 done cleared", v, cfgb);
        chk("R3 irq cleared", int'(irq[ch]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v, run, exp_win;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_chan = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
        dev_en = 2'b00; stall = 1'b0; phase = 1'b0; proc_req = 1'b1;
        mon_on = 1'b0; mon_ch = 0; mon_n = 0; acks = 0; gnt = 0; first_ch = -1;
        dev_idx[0] = 0; dev_idx[1] = 0; prog_addr[0] = 0; prog_addr[1] = 0;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 3; s++) begin
                rd(c, s, v); chk("R1 reset register value", v, 0);
            end
        end
        chk("R9 processor granted when idle", int'(proc_gnt), 1);
        chk("R1 no memory request after reset", int'(mem_req), 0);
        chk("R3 no irq after reset", int'(irq), 0);

        // sweep: direction, bus mode, channel, length
        run = 0;
        for (int d = 0; d < 2; d++)
            for (int b = 0; b < 2; b++)
                for (int c = 0; c < 2; c++)
                    for (int n = 1; n <= 4; n++) begin
                        run_xfer(c, d, b, n, 8 * run);
                        run++;
                    end
        stall = 1'b0;

        // R5: zero count
        wr(0, 0, 16'h0070);
        wr(0, 1, 0);
        wr(0, 2, 1);
        rd(0, 2, v); chk("R5 zero count: done without busy", v, 2);
        rd(0, 0, v); chk("R5 zero count: pointer unchanged", v, 16'h0070);
        prog_addr[0] = 16'h0070;
        wr(0, 2, 2);

        // R6: locked registers and start while busy
        wr(1, 0, 16'h0040);
        wr(1, 1, 3);
        wr(1, 2, 1);
        wr(1, 0, 16'h0099);
        wr(1, 1, 7);
        rd(1, 0, v); chk("R6 pointer write ignored while busy", v, 16'h0040);
        rd(1, 1, v); chk("R6 count write ignored while busy", v, 3);
        wr(1, 2, 1);
        rd(1, 2, v); chk("R6 restart sets error", v, 5);
        dev_en[1] = 1'b1;
        wait_idle(1);
        dev_en[1] = 1'b0;
        rd(1, 0, v); chk("R6 original block length kept", v, 16'h0043);
        rd(1, 2, v); chk("R6 done with error", v, 6);
        wr(1, 2, 2);
        rd(1, 2, v); chk("R6 clear removes error", v, 0);
        prog_addr[1] = 16'h0043;

        // R10 / R9: both channels ready in the same cycle
        for (int f = 0; f < 4; f++) begin
            wr(0, 0, 16'h00A0);
            wr(0, 1, 2);
            wr(0, 2, 1 | ((f & 1) << 6));
            wr(1, 0, 16'h00B0);
            wr(1, 1, 2);
            wr(1, 2, 1 | (((f >> 1) & 1) << 6));
            mon_ch = 0; mon_n = 2; acks = 0; gnt = 0; first_ch = -1;
            mon_on = 1'b1;
            dev_en = 2'b11;
            #1 chk("R9 DMA pending blocks processor", int'(proc_gnt), 0);
            wait_idle(0);
            wait_idle(1);
            dev_en = 2'b00;
            mon_on = 1'b0;
            exp_win = (f == 2) ? 1 : 0;
            chk("R10 first channel served", first_ch, exp_win);
            rd(0, 1, v); chk("R4 channel 0 finished", v, 0);
            rd(1, 1, v); chk("R4 channel 1 finished", v, 0);
            wr(0, 2, 2);
            wr(1, 2, 2);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule